// File: doc/BRIEF.md
# Run-Length Violation Detector

This block watches a received parallel data stream, one 32-bit word per accepted cycle, and counts how many identical bits arrive in a row. A run of ones and a run of zeros are treated the same way. When any run becomes longer than a programmable threshold, the block raises a violation flag. The flag stays high for a minimum time so that slower logic can see it.

A run is not reset at a word edge. The last bit of one word and the first bit of the next word are neighbours in the serial stream, so a long run split over several words is still counted as one run. The threshold is selected in steps of eight bits, from 8 up to 512. The whole detector can be switched off with an enable input, and the flag then stays low.

Top module: `run_length_guard`

## Requirements
- R1: A run is a sequence of consecutive equal bits (ones or zeros). The flag is raised when a run reaches threshold+1 bits. A run of exactly the threshold length does not raise it.
- R2: The threshold is 8 × `lim_sel`, where `lim_sel` is 1..63. The code 0 selects 512. The code is sampled with each accepted word.
- R3: Within a word, bit 0 is the earliest bit and bit 31 the latest. A run that ends at bit 31 continues into bit 0 of the next accepted word when the two bits are equal, and this holds across any number of words.
- R4: `viol` rises in the cycle after the clock edge that accepts a violating word. A single violation keeps it high for exactly two cycles.
- R5: A violating word that arrives while the flag is high restarts the two-cycle minimum, so the flag stays high without a gap.
- R6: While `en` is low, `viol` is low and the run state is cleared. After `en` returns high, the first accepted word starts a new run.
- R7: An arbitrarily long run is counted up to a saturation value above 512 and never wraps. With the 512 threshold, a run of 32 × 17 bits keeps the flag high from the seventeenth word onward.
- R8: Cycles with `din_valid` low are ignored. Their `din` value neither extends nor breaks the current run, and they raise no flag.
- R9: A synchronous reset clears the carried run, the stored last bit and the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Detector enable |
| lim_sel | input | 6 | Threshold code (threshold = 8 × code, 0 means 512) |
| din | input | 32 | Received word, bit 0 earliest |
| din_valid | input | 1 | Qualifies `din` |
| viol | output | 1 | Run-length violation flag |

## Verification
The bench uses the default parameters: 32-bit words, a step of eight, a 6-bit code and a two-cycle minimum. With these values every one of the 64 codes can be tried with runs of exactly the threshold and one bit more. The 512 threshold needs runs of seventeen words, so the cross-word carry and its saturation are both exercised. The two-cycle minimum is short enough that a single violation, a repeated violation and a disable that cuts the flag short can each be checked one cycle at a time.

// File: rtl/run_length_guard.sv
module run_length_guard #(
  parameter int W     = 32,
  parameter int STEP  = 8,
  parameter int SEL_W = 6,
  parameter int HOLD  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] lim_sel,
  input  logic [W-1:0]     din,
  input  logic             din_valid,
  output logic             viol
);

  localparam int SAT = STEP * (2 ** SEL_W) + 1;
  localparam int CW  = $clog2(SAT + 1);
  localparam int EW  = CW + 1;
  localparam int LW  = $clog2(W + 1);
  localparam int HW  = $clog2(HOLD + 1);

  logic [CW-1:0] carry_q;
  logic          last_q;
  logic          flag_q;
  logic [HW-1:0] hold_q;

  logic [LW-1:0] cur, lead, best;
  logic          in_lead;

  always_comb begin
    cur     = LW'(1);
    lead    = LW'(1);
    best    = LW'(1);
    in_lead = 1'b1;
    for (int i = 1; i < W; i++) begin
      if (din[i] == din[i-1]) cur = cur + 1'b1;
      else begin
        cur     = LW'(1);
        in_lead = 1'b0;
      end
      if (in_lead) lead = cur;
      if (cur > best) best = cur;
    end
  end

  logic             all_same, cont;
  logic [SEL_W:0]   sel_eff;
  logic [EW-1:0]    thr, eff_lead, grown;
  logic [CW-1:0]    next_carry;
  logic             hit;

  assign all_same = (lead == LW'(W));
  assign cont     = (carry_q != '0) && (din[0] == last_q);
  assign sel_eff  = (lim_sel == '0) ? (SEL_W+1)'(2 ** SEL_W) : {1'b0, lim_sel};
  assign thr      = EW'(sel_eff) * EW'(STEP);
  assign eff_lead = cont ? EW'(carry_q) + EW'(lead) : EW'(lead);
  assign grown    = (eff_lead > EW'(SAT)) ? EW'(SAT) : eff_lead;
  assign next_carry = all_same ? CW'(grown) : CW'(cur);
  assign hit      = din_valid && ((eff_lead > thr) || (EW'(best) > thr));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      carry_q <= '0;
      last_q  <= 1'b0;
      flag_q  <= 1'b0;
      hold_q  <= '0;
    end else begin
      if (din_valid) begin
        carry_q <= next_carry;
        last_q  <= din[W-1];
      end
      if (hit) begin
        flag_q <= 1'b1;
        hold_q <= HW'(HOLD - 1);
      end else if (hold_q != '0) begin
        hold_q <= hold_q - 1'b1;
      end else begin
        flag_q <= 1'b0;
      end
    end
  end

  assign viol = en && flag_q;

  assert_flag_from_word_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(din_valid));

  assert_min_width_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(flag_q) && en) |=> flag_q);

  assert_retrigger_R5: assert property (@(posedge clk) disable iff (rst)
    (flag_q && hit && en) |=> (flag_q && hold_q == HW'(HOLD - 1)));

  assert_disable_clears_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!flag_q && carry_q == '0));

  assert_carry_sat_R7: assert property (@(posedge clk) disable iff (rst)
    carry_q <= CW'(SAT));

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (en && !din_valid) |=> ($stable(carry_q) && $stable(last_q)));

  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> (!flag_q && carry_q == '0));

endmodule

// File: tb/run_length_guard_tb.sv
module run_length_guard_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b1;
  logic [5:0]  lim_sel = 6'd1;
  logic [31:0] din = '0;
  logic        din_valid = 1'b0;
  logic        viol;

  int checks = 0;
  int errors = 0;

  int m_run = 0;
  bit m_bit = 1'b0;
  bit m_flag = 1'b0;
  int m_hold = 0;
  bit seen_hi = 1'b0;

  bit [31:0] sbuf = '0;
  int        scnt = 0;
  bit        lastb = 1'b0;

  always #10ns clk = ~clk;

  run_length_guard dut_i (
    .clk(clk), .rst(rst), .en(en), .lim_sel(lim_sel),
    .din(din), .din_valid(din_valid), .viol(viol)
  );

  function automatic int thr_of(input logic [5:0] code);
    return 8 * ((code == 6'd0) ? 64 : int'(code));
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit valid, input logic [31:0] data, input string tag);
    bit hit;
    @(negedge clk);
    din = data;
    din_valid = valid;
    if (rst || !en) begin
      m_run = 0; m_flag = 1'b0; m_hold = 0;
    end else begin
      hit = 1'b0;
      if (valid) begin
        for (int i = 0; i < 32; i++) begin
          if (m_run > 0 && data[i] == m_bit) m_run++;
          else m_run = 1;
          m_bit = data[i];
          if (m_run > thr_of(lim_sel)) hit = 1'b1;
        end
      end
      if (hit) begin m_flag = 1'b1; m_hold = 1; end
      else if (m_hold > 0) m_hold--;
      else m_flag = 1'b0;
    end
    @(posedge clk);
    #1ns;
    if (viol) seen_hi = 1'b1;
    chk(int'(viol), int'(en && m_flag), tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 32'h0, tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(1'b0, 32'h0, "R9");
    step(1'b0, 32'h0, "R9");
    chk(int'(viol), 0, "R9 flag low in reset");
    rst = 1'b0;
  endtask

  task automatic push_bit(input bit b, input string tag);
    sbuf[scnt] = b;
    lastb = b;
    scnt++;
    if (scnt == 32) begin
      step(1'b1, sbuf, tag);
      scnt = 0;
    end
  endtask

  task automatic run_case(input bit v, input int len, input string tag);
    seen_hi = 1'b0;
    step(1'b1, v ? 32'h5555_5555 : 32'hAAAA_AAAA, tag);
    for (int i = 0; i < len; i++) push_bit(v, tag);
    push_bit(!v, tag);
    while (scnt != 0) push_bit(!lastb, tag);
    step(1'b1, lastb ? 32'hAAAA_AAAA : 32'h5555_5555, tag);
    idle(3, tag);
    chk(int'(seen_hi), int'(len > thr_of(lim_sel)), tag);
  endtask

  task automatic t_reset();
    chk(int'(viol), 0, "R9 reset state");
    lim_sel = 6'd3;
    step(1'b1, 32'hAAAA_AAAA, "R9");
    step(1'b1, 32'hFFF0_0000, "R9");
    do_reset();
    seen_hi = 1'b0;
    step(1'b1, 32'hAAAA_FFFF, "R9");
    idle(3, "R9");
    chk(int'(seen_hi), 0, "R9 carried run cleared by reset");
  endtask

  task automatic t_threshold();
    lim_sel = 6'd1;
    run_case(1'b1, 8, "R1 ones at threshold");
    run_case(1'b1, 9, "R1 ones above threshold");
    run_case(1'b0, 8, "R1 zeros at threshold");
    run_case(1'b0, 9, "R1 zeros above threshold");
    lim_sel = 6'd5;
    run_case(1'b1, 40, "R1 forty at threshold");
    run_case(1'b0, 41, "R1 forty-one zeros");
  endtask

  task automatic t_limits();
    for (int c = 0; c < 64; c++) begin
      lim_sel = 6'(c);
      run_case(c[0], thr_of(lim_sel), "R2 limit code exact");
      run_case(!c[0], thr_of(lim_sel) + 1, "R2 limit code plus one");
    end
  endtask

  task automatic t_order();
    lim_sel = 6'd3;
    seen_hi = 1'b0;
    step(1'b1, 32'hAAAA_AAAA, "R3");
    step(1'b1, 32'hFFF0_0000, "R3");
    step(1'b1, 32'hAAAA_AFFF, "R3");
    idle(3, "R3");
    chk(int'(seen_hi), 0, "R3 two-word run of 24");
    seen_hi = 1'b0;
    step(1'b1, 32'hFFF0_0000, "R3");
    step(1'b1, 32'hAAAA_FFFF, "R3");
    idle(3, "R3");
    chk(int'(seen_hi), 1, "R3 two-word run of 28");
    lim_sel = 6'd8;
    seen_hi = 1'b0;
    step(1'b1, 32'hFFFF_0000, "R3");
    step(1'b1, 32'hFFFF_FFFF, "R3");
    step(1'b1, 32'hAAAA_FFFF, "R3");
    idle(3, "R3");
    chk(int'(seen_hi), 0, "R3 three-word run of 64");
    seen_hi = 1'b0;
    step(1'b1, 32'hFFFF_0000, "R3");
    step(1'b1, 32'hFFFF_FFFF, "R3");
    step(1'b1, 32'hAAAB_FFFF, "R3");
    idle(3, "R3");
    chk(int'(seen_hi), 1, "R3 three-word run of 66");
  endtask

  task automatic t_stretch();
    lim_sel = 6'd1;
    step(1'b1, 32'hAAAA_AAAA, "R4");
    step(1'b1, 32'hFFFF_0000, "R4");
    chk(int'(viol), 1, "R4 first high cycle");
    step(1'b0, 32'h0, "R4");
    chk(int'(viol), 1, "R4 second high cycle");
    step(1'b0, 32'h0, "R4");
    chk(int'(viol), 0, "R4 falls after two cycles");
  endtask

  task automatic t_retrigger();
    lim_sel = 6'd1;
    step(1'b1, 32'hFFFF_FFFF, "R5");
    chk(int'(viol), 1, "R5 first hit");
    step(1'b0, 32'h0, "R5");
    step(1'b1, 32'h0000_0000, "R5");
    chk(int'(viol), 1, "R5 second hit keeps flag");
    step(1'b0, 32'h0, "R5");
    chk(int'(viol), 1, "R5 restarted minimum");
    step(1'b0, 32'h0, "R5");
    chk(int'(viol), 0, "R5 falls after restarted minimum");
  endtask

  task automatic t_disable();
    lim_sel = 6'd1;
    step(1'b1, 32'hFFFF_FFFF, "R6");
    chk(int'(viol), 1, "R6 flag set before disable");
    en = 1'b0;
    step(1'b0, 32'h0, "R6");
    chk(int'(viol), 0, "R6 disable drops flag");
    seen_hi = 1'b0;
    step(1'b1, 32'h0000_0000, "R6");
    step(1'b1, 32'hFFFF_FFFF, "R6");
    chk(int'(seen_hi), 0, "R6 no flag while disabled");
    en = 1'b1;
    idle(2, "R6");
    lim_sel = 6'd3;
    step(1'b1, 32'hAAAA_AAAA, "R6");
    step(1'b1, 32'hFFF0_0000, "R6");
    en = 1'b0;
    step(1'b0, 32'h0, "R6");
    en = 1'b1;
    seen_hi = 1'b0;
    step(1'b1, 32'hAAAA_FFFF, "R6");
    idle(3, "R6");
    chk(int'(seen_hi), 0, "R6 run restarted after enable");
  endtask

  task automatic t_long();
    lim_sel = 6'd0;
    step(1'b1, 32'h5555_5555, "R7");
    for (int i = 1; i <= 40; i++) begin
      step(1'b1, 32'hFFFF_FFFF, "R7");
      chk(int'(viol), int'(i * 32 > 512), "R7 long run word");
    end
    step(1'b1, 32'hAAAA_AAAA, "R7");
    idle(2, "R7");
    chk(int'(viol), 0, "R7 flag clears after run ends");
  endtask

  task automatic t_idle();
    lim_sel = 6'd3;
    seen_hi = 1'b0;
    step(1'b1, 32'hAAAA_AAAA, "R8");
    step(1'b1, 32'hFFF0_0000, "R8");
    for (int i = 0; i < 3; i++) step(1'b0, 32'h0000_0000, "R8");
    step(1'b1, 32'hAAAA_AFFF, "R8");
    idle(3, "R8");
    chk(int'(seen_hi), 0, "R8 idle zeros do not break or count");
    seen_hi = 1'b0;
    step(1'b1, 32'hFFF0_0000, "R8");
    for (int i = 0; i < 3; i++) step(1'b0, 32'hFFFF_FFFF, "R8");
    step(1'b1, 32'hAAAA_AFFF, "R8");
    idle(3, "R8");
    chk(int'(seen_hi), 0, "R8 idle ones do not extend");
    seen_hi = 1'b0;
    step(1'b1, 32'hFFF0_0000, "R8");
    step(1'b0, 32'h0000_0000, "R8");
    step(1'b1, 32'hAAAA_FFFF, "R8");
    idle(3, "R8");
    chk(int'(seen_hi), 1, "R8 run continues across idle");
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20ns * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    t_reset();
    t_threshold();
    t_order();
    t_stretch();
    t_retrigger();
    t_disable();
    t_long();
    t_idle();
    t_limits();
    finish_run();
  end

endmodule